// File: doc/BRIEF.md
# Ramp Sample Interleaver for Loss-Tolerant Packets

This block takes the stream of 32-bit lock-in results produced over one laser wavelength ramp and spreads them over M packet buffers instead of filling one buffer after another. Sample k of the ramp goes to packet k mod M. Within that packet it goes to word 1 + floor(k / M). Each packet therefore carries an evenly spaced subset of the ramp. If one packet is dropped on the network, the receiver sees a coarser line shape rather than a hole in it. M is chosen per ramp from 1, 2, 4 or 8. With M = 1 the samples are stored contiguously.

A ramp-start strobe latches the configuration and restarts the sample count. In the next cycle, word 0 of every active packet receives a header that the receiver needs to undo the interleave. Each packet buffer has its own write port (enable, word address, data), so every active packet can be written in the same cycle. A narrow mode keeps only the upper 16 bits of each result and packs two results per buffer word. When the configured number of samples has been accepted, a one-cycle completion strobe marks the cycle that carries the final buffer writes.

Top module: `pkt_interleaver`

## Requirements
- R1: `cfg_m_sel` values 0, 1, 2 and 3 select M = 1, 2, 4 and 8. The sample with ramp index k (counted from 0 after ramp start) is written through buffer port k mod M.
- R2: In 32-bit mode, sample k is written unchanged to word address 1 + floor(k / M) of its packet.
- R3: In the cycle after `ramp_start` is sampled high, every port p < M writes address 0 with the header {ramp number [31:16], zeros [15:9], narrow flag [8], p [7:4], M [3:0]}. Ports p >= M make no write.
- R4: The ramp number in the header is 0 for the first ramp after reset. It increases by one with every `ramp_start`.
- R5: In narrow mode a result is reduced to its bits [31:16]. Within packet p, the samples with per-packet offset o = floor(k / M) pair into word 1 + floor(o / 2). The even offset goes into bits [15:0] and the odd offset into bits [31:16].
- R6: At the end of a ramp in narrow mode, every packet holding an unpaired result writes it with bits [31:16] zero. This write happens in the same cycle as the write for the final sample.
- R7: `ramp_done` pulses for one cycle, in the cycle where the write for the last of the `cfg_nsamp` samples appears. With `cfg_nsamp` = 0 it pulses together with the header writes, and no samples are accepted.
- R8: `s_ready` is high only from the cycle after ramp start until the last sample is accepted, and it is low while `ramp_start` is high. Samples offered while `s_ready` is low cause no write and no completion.
- R9: A `ramp_start` during an unfinished ramp abandons that ramp. Its unpaired narrow results are never written, and the new ramp begins at index 0 with fresh headers.
- R10: `cfg_m_sel`, `cfg_half` and `cfg_nsamp` are sampled only at `ramp_start`. Changing them during a ramp does not alter that ramp's mapping or length.
- R11: The write for an accepted sample appears in the cycle after acceptance. Idle cycles between samples do not change the mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_m_sel | input | 2 | Interleave ratio select, log2 of M |
| cfg_half | input | 1 | Narrow mode: 16-bit results, two per word |
| cfg_nsamp | input | 10 | Samples per ramp |
| ramp_start | input | 1 | Ramp start strobe |
| s_valid | input | 1 | Input sample valid |
| s_data | input | 32 | Input lock-in result |
| s_ready | output | 1 | Input sample accepted when high with s_valid |
| buf_we | output | 8 | Per-packet buffer write enable |
| buf_addr | output | 8x10 | Per-packet buffer word address |
| buf_wdata | output | 8x32 | Per-packet buffer write data |
| ramp_done | output | 1 | Ramp completion strobe |

## Verification
The hardest state to reach from the ports is a ramp that is restarted while several packets still hold an unpaired narrow result. If that happens, a stale flush could leak into the next ramp's final cycle. To reach it, the stimulus runs an M = 4 narrow ramp and stops after six samples, which leaves packets 2 and 3 half-filled. It then restarts in 32-bit mode and counts every write of the new ramp exactly. A separate M = 8 narrow ramp of 19 samples leaves a different mix of paired and unpaired packets at its end. This shows that the flushes arrive alongside the final sample's write in the cycle of the completion strobe.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int RAMP_W = 16;

  // header word layout: ramp number, reserved, narrow flag, packet index, ratio
  function automatic logic [WORD_W-1:0] make_hdr(input logic [RAMP_W-1:0] ramp,
                                                  input logic narrow,
                                                  input logic [3:0] pkt,
                                                  input logic [3:0] ratio);
    return {ramp, 7'b0, narrow, pkt, ratio};
  endfunction
endpackage

// File: rtl/ilv_seq.sv
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int SAMP_W = 10,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ramp_start,
  input  logic [SEL_W-1:0]  cfg_m_sel,
  input  logic              cfg_half,
  input  logic [SAMP_W-1:0] cfg_nsamp,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              acc,
  output logic              last,
  output logic [SAMP_W-1:0] cnt_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic              half_q,
  output logic [RAMP_W-1:0] ramp_q,
  output logic              done_q
);
  logic              busy_q, busy_n;
  logic [SAMP_W-1:0] cnt_n, n_q, n_n;
  logic [SEL_W-1:0]  sel_n;
  logic              half_n, done_n;
  logic [RAMP_W-1:0] ramp_n;
  logic              cfg_en;

  always_comb begin
    s_ready = busy_q & ~ramp_start;
    acc     = s_valid & s_ready;
    last    = acc & (cnt_q == (n_q - SAMP_W'(1)));
    cfg_en  = ramp_start;
    busy_n  = busy_q;
    cnt_n   = cnt_q;
    sel_n   = sel_q;
    half_n  = half_q;
    n_n     = n_q;
    ramp_n  = ramp_q;
    done_n  = 1'b0;
    if (ramp_start) begin
      busy_n = |cfg_nsamp;
      cnt_n  = '0;
      sel_n  = cfg_m_sel;
      half_n = cfg_half;
      n_n    = cfg_nsamp;
      ramp_n = ramp_q + RAMP_W'(1);
      done_n = ~|cfg_nsamp;
    end else if (acc) begin
      cnt_n = cnt_q + SAMP_W'(1);
      if (last) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      ramp_q <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
      ramp_q <= ramp_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      half_q <= 1'b0;
      n_q    <= '0;
    end else if (cfg_en) begin
      sel_q  <= sel_n;
      half_q <= half_n;
      n_q    <= n_n;
    end
  end
endmodule

// File: rtl/ilv_lane.sv
module ilv_lane
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_en,
  input  logic [WORD_W-1:0] hdr,
  input  logic              acc,
  input  logic [ADDR_W-1:0] off,
  input  logic              half,
  input  logic              last,
  input  logic [WORD_W-1:0] din,
  output logic              we_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORD_W-1:0] data_q
);
  logic              we_n;
  logic [ADDR_W-1:0] addr_n, haddr_q, haddr_n, word_full, word_half;
  logic [WORD_W-1:0] data_n;
  logic              pend_q, pend_n, hold_en;
  logic [HALF_W-1:0] hold_q, hold_n;

  always_comb begin
    word_full = off + ADDR_W'(1);
    word_half = (off >> 1) + ADDR_W'(1);
    we_n      = 1'b0;
    addr_n    = addr_q;
    data_n    = data_q;
    pend_n    = pend_q;
    hold_en   = 1'b0;
    hold_n    = hold_q;
    haddr_n   = haddr_q;
    if (start) begin
      pend_n = 1'b0;
      if (start_en) begin
        we_n   = 1'b1;
        addr_n = '0;
        data_n = hdr;
      end
    end else if (acc) begin
      if (!half) begin
        we_n   = 1'b1;
        addr_n = word_full;
        data_n = din;
      end else if (!off[0]) begin
        if (last) begin
          we_n   = 1'b1;
          addr_n = word_half;
          data_n = {{HALF_W{1'b0}}, din[WORD_W-1:HALF_W]};
          pend_n = 1'b0;
        end else begin
          pend_n  = 1'b1;
          hold_en = 1'b1;
          hold_n  = din[WORD_W-1:HALF_W];
          haddr_n = word_half;
        end
      end else begin
        we_n   = 1'b1;
        addr_n = word_half;
        data_n = {din[WORD_W-1:HALF_W], hold_q};
        pend_n = 1'b0;
      end
    end else if (last && pend_q) begin
      we_n   = 1'b1;
      addr_n = haddr_q;
      data_n = {{HALF_W{1'b0}}, hold_q};
      pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      pend_q <= 1'b0;
    end else begin
      we_q   <= we_n;
      addr_q <= addr_n;
      data_q <= data_n;
      pend_q <= pend_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      haddr_q <= '0;
    end else if (hold_en) begin
      hold_q  <= hold_n;
      haddr_q <= haddr_n;
    end
  end
endmodule

// File: rtl/pkt_interleaver.sv
module pkt_interleaver
  import ilv_pkg::*;
#(
  parameter int NPKT_LOG2 = 3,
  parameter int SAMP_W    = 10,
  parameter int NPKT      = 1 << NPKT_LOG2,
  parameter int SEL_W     = $clog2(NPKT_LOG2 + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [SEL_W-1:0]                cfg_m_sel,
  input  logic                            cfg_half,
  input  logic [SAMP_W-1:0]               cfg_nsamp,
  input  logic                            ramp_start,
  input  logic                            s_valid,
  input  logic [WORD_W-1:0]               s_data,
  output logic                            s_ready,
  output logic [NPKT-1:0]                 buf_we,
  output logic [NPKT-1:0][SAMP_W-1:0]     buf_addr,
  output logic [NPKT-1:0][WORD_W-1:0]     buf_wdata,
  output logic                            ramp_done
);
  localparam int ADDR_W = SAMP_W;

  logic                  acc, last, half_q;
  logic [SAMP_W-1:0]     cnt_q, off;
  logic [SEL_W-1:0]      sel_q;
  logic [RAMP_W-1:0]     ramp_q;
  logic [NPKT_LOG2-1:0]  pmask, pidx;
  logic [3:0]            ratio_in;

  ilv_seq #(.SAMP_W(SAMP_W), .SEL_W(SEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ramp_start(ramp_start),
    .cfg_m_sel(cfg_m_sel), .cfg_half(cfg_half), .cfg_nsamp(cfg_nsamp),
    .s_valid(s_valid), .s_ready(s_ready), .acc(acc), .last(last),
    .cnt_q(cnt_q), .sel_q(sel_q), .half_q(half_q), .ramp_q(ramp_q),
    .done_q(ramp_done)
  );

  // power-of-two ratio: packet index from low counter bits, offset from the rest
  always_comb begin
    pmask    = NPKT_LOG2'((32'd1 << sel_q) - 32'd1);
    pidx     = cnt_q[NPKT_LOG2-1:0] & pmask;
    off      = cnt_q >> sel_q;
    ratio_in = 4'(32'd1 << cfg_m_sel);
  end

  for (genvar i = 0; i < NPKT; i++) begin : g_lane
    logic              lane_acc, lane_en;
    logic [WORD_W-1:0] lane_hdr;

    always_comb begin
      lane_acc = acc && (pidx == NPKT_LOG2'(i));
      lane_en  = (32'(i) < (32'd1 << cfg_m_sel));
      lane_hdr = make_hdr(ramp_q, cfg_half, 4'(i), ratio_in);
    end

    ilv_lane #(.ADDR_W(ADDR_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .start(ramp_start), .start_en(lane_en),
      .hdr(lane_hdr), .acc(lane_acc), .off(off), .half(half_q),
      .last(last), .din(s_data),
      .we_q(buf_we[i]), .addr_q(buf_addr[i]), .data_q(buf_wdata[i])
    );
  end
endmodule

// File: rtl/ilv_checker.sv
module ilv_checker #(
  parameter int NPKT   = 8,
  parameter int ADDR_W = 10
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ramp_start,
  input logic                        s_valid,
  input logic                        s_ready,
  input logic                        ramp_done,
  input logic                        half_q,
  input logic [NPKT-1:0]             buf_we,
  input logic [NPKT-1:0][ADDR_W-1:0] buf_addr
);
  a_r8_start_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_start |-> !s_ready);

  a_r3_hdr_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_start |=> (buf_we[0] && buf_addr[0] == '0));

  a_r7_done_has_write: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done |-> (buf_we != '0));

  a_r7_done_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done |-> !s_ready);

  a_r11_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !half_q) |=> ($countones(buf_we) == 1));
endmodule

bind pkt_interleaver ilv_checker #(.NPKT(NPKT), .ADDR_W(SAMP_W)) u_ilv_chk (
  .clk(clk), .rst_n(rst_n), .ramp_start(ramp_start), .s_valid(s_valid),
  .s_ready(s_ready), .ramp_done(ramp_done), .half_q(half_q),
  .buf_we(buf_we), .buf_addr(buf_addr)
);

// File: tb/pkt_interleaver_bench.sv
module pkt_interleaver_bench;
  localparam int NP = 8;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cfg_m_sel;
  logic cfg_half;
  logic [AW-1:0] cfg_nsamp;
  logic ramp_start, s_valid;
  logic [31:0] s_data;
  logic s_ready, ramp_done;
  logic [NP-1:0] buf_we;
  logic [NP-1:0][AW-1:0] buf_addr;
  logic [NP-1:0][31:0] buf_wdata;

  int tests = 0, fails = 0, cyc = 0;
  int nwr, done_cnt, done_cyc, lastwr_cyc;
  logic [31:0] mem [NP][64];
  logic        wr  [NP][64];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pkt_interleaver u_pkt_interleaver (
    .clk(clk), .rst_n(rst_n), .cfg_m_sel(cfg_m_sel), .cfg_half(cfg_half),
    .cfg_nsamp(cfg_nsamp), .ramp_start(ramp_start), .s_valid(s_valid),
    .s_data(s_data), .s_ready(s_ready), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .ramp_done(ramp_done)
  );

  always @(negedge clk) if (rst_n) begin
    for (int p = 0; p < NP; p++) if (buf_we[p]) begin
      nwr++;
      lastwr_cyc = cyc;
      if (buf_addr[p] < 64) begin
        mem[p][buf_addr[p]] = buf_wdata[p];
        wr[p][buf_addr[p]]  = 1'b1;
      end
    end
    if (ramp_done) begin
      done_cnt++;
      done_cyc = cyc;
    end
  end

  function automatic logic [31:0] smp(input int k);
    return {16'h4000 + 16'(k * 7), 16'h00F0 ^ 16'(k)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem;
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < 64; a++) begin
        mem[p][a] = 'x;
        wr[p][a]  = 1'b0;
      end
    nwr = 0; done_cnt = 0; done_cyc = -1; lastwr_cyc = -2;
  endtask

  task automatic start_ramp(input int sel, input logic half, input int n);
    cfg_m_sel = 2'(sel); cfg_half = half; cfg_nsamp = AW'(n);
    ramp_start = 1'b1;
    @(negedge clk);
    ramp_start = 1'b0;
  endtask

  task automatic push(input int k);
    s_valid = 1'b1; s_data = smp(k);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic verify(input int sel, input logic half, input int n, input int ramp);
    int m, exp_wr;
    m = 1 << sel;
    exp_wr = m;
    @(negedge clk); #1;
    for (int p = 0; p < NP; p++) begin
      if (p < m)
        chk($sformatf("R3/R4 header pkt%0d", p), mem[p][0],
            {16'(ramp), 7'b0, half, 4'(p), 4'(m)});
      else
        chk($sformatf("R3 no header pkt%0d", p), 32'(wr[p][0]), 32'd0);
    end
    for (int k = 0; k < n; k++) begin
      int p, o;
      p = k % m; o = k / m;
      if (!half) begin
        chk($sformatf("R1/R2 k%0d pkt%0d", k, p), mem[p][1 + o], smp(k));
        exp_wr++;
      end else if (o % 2 == 0) begin
        logic [15:0] lo, hi;
        lo = smp(k) >> 16;
        hi = (k + m < n) ? 16'(smp(k + m) >> 16) : 16'h0;
        chk($sformatf("R5/R6 k%0d pkt%0d", k, p), mem[p][1 + o / 2], {hi, lo});
        exp_wr++;
      end
    end
    chk("R9 write count", 32'(nwr), 32'(exp_wr));
    chk("R7 done count", 32'(done_cnt), 32'd1);
    chk("R6/R7 done with final write", 32'(done_cyc), 32'(lastwr_cyc));
  endtask

  task automatic t_reset;
    chk("R8 reset ready", 32'(s_ready), 32'd0);
    chk("R7 reset done", 32'(ramp_done), 32'd0);
    chk("R3 reset writes", 32'(buf_we), 32'd0);
  endtask

  task automatic t_m1_full;
    clear_mem;
    start_ramp(0, 1'b0, 5);
    for (int k = 0; k < 5; k++) push(k);
    verify(0, 1'b0, 5, 0);
  endtask

  task automatic t_m4_gaps;
    clear_mem;
    start_ramp(2, 1'b0, 10);
    cfg_m_sel = 2'd0; cfg_half = 1'b1; cfg_nsamp = AW'(3); // R10: ignored mid-ramp
    for (int k = 0; k < 10; k++) begin
      push(k);
      if (k % 2 == 0) @(negedge clk); // R11: idle gaps
    end
    verify(2, 1'b0, 10, 1);
  endtask

  task automatic t_m8_half;
    clear_mem;
    start_ramp(3, 1'b1, 19);
    for (int k = 0; k < 19; k++) push(k);
    verify(3, 1'b1, 19, 2);
  endtask

  task automatic t_m2_half_even;
    clear_mem;
    start_ramp(1, 1'b1, 8);
    for (int k = 0; k < 8; k++) push(k);
    verify(1, 1'b1, 8, 3);
  endtask

  task automatic t_idle_ignored;
    clear_mem;
    for (int k = 0; k < 3; k++) begin
      chk("R8 ready low when idle", 32'(s_ready), 32'd0);
      push(k);
    end
    @(negedge clk); #1;
    chk("R8 idle writes", 32'(nwr), 32'd0);
    chk("R8 idle done", 32'(done_cnt), 32'd0);
  endtask

  task automatic t_abort;
    clear_mem;
    start_ramp(2, 1'b1, 12);
    for (int k = 0; k < 6; k++) push(k);
    @(negedge clk); #1;
    clear_mem;
    start_ramp(1, 1'b0, 4);
    for (int k = 0; k < 4; k++) push(k);
    verify(1, 1'b0, 4, 5);
  endtask

  task automatic t_zero;
    clear_mem;
    start_ramp(1, 1'b0, 0);
    #1;
    chk("R7 zero-length done", 32'(done_cnt), 32'd1);
    chk("R7 done with headers", 32'(done_cyc), 32'(lastwr_cyc));
    chk("R3 zero-length header count", 32'(nwr), 32'd2);
    chk("R4 zero-length ramp number", mem[1][0], {16'd6, 7'b0, 1'b0, 4'd1, 4'd2});
    chk("R8 zero-length ready", 32'(s_ready), 32'd0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_m_sel = '0; cfg_half = 1'b0; cfg_nsamp = '0;
    ramp_start = 1'b0; s_valid = 1'b0; s_data = '0;
    clear_mem;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset;
    t_m1_full;
    t_m4_gaps;
    t_m8_half;
    t_m2_half_even;
    t_idle_ignored;
    t_abort;
    t_zero;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule